// File: doc/BRIEF.md
# Register Rename Map with Free List

This block gives each instruction's architectural registers their physical names at dispatch. It handles one instruction per cycle, in program order. Both source register numbers are looked up in a map table. If the instruction writes a register, a physical register is taken from a free list and the map table is updated to point at it.

For a writing instruction the block also returns the physical register that the destination mapped to before. The pipeline carries this tag to commit and hands it back through the commit port. At that point the physical register re-enters the free list, because no later instruction can read it. When no physical register is free, a writing instruction is held with a stall. Renaming state lives in a single physical register space of 64 entries that backs 32 architectural registers.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i.
- R2: After reset, the free list holds physical registers 32 to 63. They are handed out in ascending order, one per writing instruction.
- R3: Source tags are read from the map before the same instruction's destination is remapped. If a source equals the destination, the source tag is the old mapping.
- R4: Once an instruction is renamed, a later instruction reading the same architectural register gets the newly allocated tag.
- R5: For a writing instruction, `out_prev_tag` is the destination's mapping just before the rename, `out_dst_valid` is 1, and `out_new_tag` differs from `out_prev_tag`.
- R6: An instruction with no destination takes nothing from the free list. Its results show `out_dst_valid` = 0 with `out_new_tag` and `out_prev_tag` both 0.
- R7: If a writing instruction is presented while the free list is empty, `ren_stall` is 1 in that same cycle and no result is produced. The map and the free list stay unchanged. An instruction without a destination is not stalled.
- R8: Tags returned through the commit port join the tail of the free list. They are allocated in the order they were returned, after any tags that were already waiting.
- R9: A tag returned in the same cycle as an empty-list stall does not relieve that stall. It can be allocated from the next cycle on.
- R10: Results are registered. They appear on the outputs one cycle after the request, and `out_valid` is 0 in any cycle that follows a cycle with no accepted request, including the cycles after reset.
- R11: While `ren_valid` is 0, the map and the free list do not change, apart from commit returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_src_a | input | 5 | First source architectural register |
| ren_src_b | input | 5 | Second source architectural register |
| ren_dst_valid | input | 1 | The instruction writes a register |
| ren_dst | input | 5 | Destination architectural register |
| ren_stall | output | 1 | The request cannot be accepted this cycle (combinational) |
| out_valid | output | 1 | Registered rename result is valid |
| out_src_a_tag | output | 6 | Physical tag of the first source |
| out_src_b_tag | output | 6 | Physical tag of the second source |
| out_dst_valid | output | 1 | The result carries a destination |
| out_new_tag | output | 6 | Newly allocated physical tag of the destination |
| out_prev_tag | output | 6 | Previous physical mapping of the destination |
| cmt_valid | input | 1 | A previous mapping is being released at commit |
| cmt_tag | input | 6 | Physical tag being released |

## Verification
The assertions check several properties on every cycle. The free list never underflows or overflows. A commit into an empty list makes it non-empty on the next cycle. A stall always suppresses the next result. A new tag never equals the mapping it replaces. Whether each tag value is right needs the bench's scenarios, which compare against a reference map and free queue. These cover the identity mapping after reset, the ascending first allocations, a source that equals the destination, running the list dry, a commit during a stall, and the FIFO order of returned tags.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned RN_ARCH_REGS = 32;
  localparam int unsigned RN_PHYS_REGS = 64;

  typedef enum logic [1:0] {
    FL_HOLD = 2'b00,
    FL_TAKE = 2'b01,
    FL_GIVE = 2'b10,
    FL_SWAP = 2'b11
  } fl_op_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NARCH = 32,
  parameter int NPHYS = 64,
  parameter int AW    = $clog2(NARCH),
  parameter int TW    = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  input  logic [AW-1:0] rd_d_idx,
  output logic [TW-1:0] rd_a_tag,
  output logic [TW-1:0] rd_b_tag,
  output logic [TW-1:0] rd_d_tag,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag
);
  logic [TW-1:0] tbl [NARCH];

  // three asynchronous read ports see the table before this cycle's write
  assign rd_a_tag = tbl[rd_a_idx];
  assign rd_b_tag = tbl[rd_b_idx];
  assign rd_d_tag = tbl[rd_d_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NARCH; i++) tbl[i] <= TW'(i);
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_tag;
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
  import rn_pkg::*;
#(
  parameter int NARCH = 32,
  parameter int NPHYS = 64,
  parameter int TW    = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  output logic [TW-1:0] head_tag,
  output logic          empty,
  input  logic          push,
  input  logic [TW-1:0] push_tag
);
  localparam int DEPTH = NPHYS - NARCH;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [TW-1:0] slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  fl_op_e        op;

  assign op       = fl_op_e'({push, pop});
  assign empty    = (count == '0);
  assign head_tag = slots[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= TW'(NARCH + i);
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= CW'(DEPTH);
    end else begin
      if (push) slots[wr_ptr] <= push_tag;
      case (op)
        FL_TAKE: begin
          rd_ptr <= bump(rd_ptr);
          count  <= count - CW'(1);
        end
        FL_GIVE: begin
          wr_ptr <= bump(wr_ptr);
          count  <= count + CW'(1);
        end
        FL_SWAP: begin
          rd_ptr <= bump(rd_ptr);
          wr_ptr <= bump(wr_ptr);
        end
        default: ;
      endcase
    end
  end

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (count != CW'(DEPTH)));
  p_refill_next_r9: assert property (@(posedge clk) disable iff (rst)
    (push && empty) |=> !empty);
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int NUM_ARCH = rn_pkg::RN_ARCH_REGS,
  parameter int NUM_PHYS = rn_pkg::RN_PHYS_REGS,
  parameter int AW       = $clog2(NUM_ARCH),
  parameter int TW       = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic          ren_dst_valid,
  input  logic [AW-1:0] ren_dst,
  output logic          ren_stall,
  output logic          out_valid,
  output logic [TW-1:0] out_src_a_tag,
  output logic [TW-1:0] out_src_b_tag,
  output logic          out_dst_valid,
  output logic [TW-1:0] out_new_tag,
  output logic [TW-1:0] out_prev_tag,
  input  logic          cmt_valid,
  input  logic [TW-1:0] cmt_tag
);
  logic [TW-1:0] tag_a, tag_b, tag_d, free_head;
  logic          free_empty, accept, alloc;

  assign ren_stall = ren_valid && ren_dst_valid && free_empty;
  assign accept    = ren_valid && !ren_stall;
  assign alloc     = accept && ren_dst_valid;

  rn_map_table #(.NARCH(NUM_ARCH), .NPHYS(NUM_PHYS), .AW(AW), .TW(TW)) u_map (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (ren_src_a),
    .rd_b_idx (ren_src_b),
    .rd_d_idx (ren_dst),
    .rd_a_tag (tag_a),
    .rd_b_tag (tag_b),
    .rd_d_tag (tag_d),
    .wr_en    (alloc),
    .wr_idx   (ren_dst),
    .wr_tag   (free_head)
  );

  rn_free_list #(.NARCH(NUM_ARCH), .NPHYS(NUM_PHYS), .TW(TW)) u_free (
    .clk      (clk),
    .rst      (rst),
    .pop      (alloc),
    .head_tag (free_head),
    .empty    (free_empty),
    .push     (cmt_valid),
    .push_tag (cmt_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_src_a_tag <= '0;
      out_src_b_tag <= '0;
      out_dst_valid <= 1'b0;
      out_new_tag   <= '0;
      out_prev_tag  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_src_a_tag <= tag_a;
        out_src_b_tag <= tag_b;
        out_dst_valid <= ren_dst_valid;
        out_new_tag   <= ren_dst_valid ? free_head : '0;
        out_prev_tag  <= ren_dst_valid ? tag_d : '0;
      end
    end
  end

  p_stall_no_result_r7: assert property (@(posedge clk) disable iff (rst)
    ren_stall |=> !out_valid);
  p_fresh_tag_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dst_valid) |-> (out_new_tag != out_prev_tag));
  p_idle_no_result_r10: assert property (@(posedge clk) disable iff (rst)
    !ren_valid |=> !out_valid);
endmodule

// File: tb/rename_unit_test.sv
module rename_unit_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       ren_valid = 0, ren_dst_valid = 0, cmt_valid = 0;
  logic [4:0] ren_src_a = 0, ren_src_b = 0, ren_dst = 0;
  logic [5:0] cmt_tag = 0;
  logic       ren_stall, out_valid, out_dst_valid;
  logic [5:0] out_src_a_tag, out_src_b_tag, out_new_tag, out_prev_tag;

  int total = 0, bad = 0;
  int mmap [32];
  int fq [$];

  always #10 clk = ~clk;

  rename_unit uut (
    .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_src_a(ren_src_a),
    .ren_src_b(ren_src_b), .ren_dst_valid(ren_dst_valid), .ren_dst(ren_dst),
    .ren_stall(ren_stall), .out_valid(out_valid), .out_src_a_tag(out_src_a_tag),
    .out_src_b_tag(out_src_b_tag), .out_dst_valid(out_dst_valid),
    .out_new_tag(out_new_tag), .out_prev_tag(out_prev_tag),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag)
  );

  task automatic check(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one cycle of stimulus, checked against the reference map and queue
  task automatic step(input logic rv, input int sa, input int sb,
                      input logic dv, input int d, input logic cv,
                      input int ct, input string rq);
    bit ex_stall, ex_ok;
    int ex_a, ex_b, ex_new, ex_prev;
    ex_stall = rv && dv && (fq.size() == 0);
    ex_ok = rv && !ex_stall;
    ex_a = mmap[sa]; ex_b = mmap[sb]; ex_new = 0; ex_prev = 0;
    if (ex_ok && dv) begin
      ex_new = fq.pop_front();
      ex_prev = mmap[d];
      mmap[d] = ex_new;
    end
    if (cv) fq.push_back(ct);
    @(negedge clk);
    ren_valid = rv; ren_src_a = 5'(sa); ren_src_b = 5'(sb);
    ren_dst_valid = dv; ren_dst = 5'(d); cmt_valid = cv; cmt_tag = 6'(ct);
    #1;
    check({rq, " stall"}, int'(ren_stall), int'(ex_stall));
    @(posedge clk);
    #1;
    ren_valid = 0; ren_dst_valid = 0; cmt_valid = 0;
    check({rq, " out_valid"}, int'(out_valid), int'(ex_ok));
    if (ex_ok) begin
      check({rq, " src_a"}, int'(out_src_a_tag), ex_a);
      check({rq, " src_b"}, int'(out_src_b_tag), ex_b);
      check({rq, " dst_valid"}, int'(out_dst_valid), int'(dv));
      check({rq, " new"}, int'(out_new_tag), ex_new);
      check({rq, " prev"}, int'(out_prev_tag), ex_prev);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 32; i++) mmap[i] = i;
    fq.delete();
    for (int i = 32; i < 64; i++) fq.push_back(i);
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check("R10 reset out_valid", int'(out_valid), 0);
    check("R10 reset stall", int'(ren_stall), 0);
  endtask

  task automatic t_identity;
    step(1, 5, 7, 0, 0, 0, 0, "R1 identity");
    check("R1 src_a=5", int'(out_src_a_tag), 5);
    check("R6 no dest prev", int'(out_prev_tag), 0);
    step(1, 0, 31, 0, 0, 0, 0, "R1 edges");
    @(posedge clk); #1;
    check("R10 idle after accept", int'(out_valid), 0);
  endtask

  task automatic t_first_alloc;
    step(1, 3, 4, 1, 3, 0, 0, "R3 self source");
    check("R3 old mapping", int'(out_src_a_tag), 3);
    check("R2 first tag", int'(out_new_tag), 32);
    check("R5 prev tag", int'(out_prev_tag), 3);
    step(1, 3, 3, 0, 0, 0, 0, "R4 reads new");
    check("R4 src sees 32", int'(out_src_b_tag), 32);
    step(1, 1, 2, 0, 9, 0, 0, "R6 no alloc");
    step(1, 4, 3, 1, 4, 0, 0, "R6 next alloc");
    check("R6 no tag consumed", int'(out_new_tag), 33);
  endtask

  task automatic t_idle;
    step(0, 0, 0, 1, 6, 0, 0, "R11 idle");
    step(1, 6, 6, 1, 6, 0, 0, "R11 after idle");
    check("R11 tag 34", int'(out_new_tag), 34);
  endtask

  task automatic t_exhaust;
    for (int i = 0; i < 29; i++) step(1, i, (i + 1) % 32, 1, (i * 7) % 32, 0, 0, "R2 drain");
    check("R2 last tag", int'(out_new_tag), 63);
    step(1, 2, 3, 1, 2, 0, 0, "R7 empty stall");
    step(1, 2, 3, 0, 0, 0, 0, "R7 nodest passes");
    step(1, 2, 14, 0, 0, 0, 0, "R7 map unchanged");
  endtask

  task automatic t_commit_on_stall;
    int x;
    x = mmap[20];
    step(1, 1, 1, 1, 10, 1, 5, "R9 same cycle");
    check("R9 still stalled", int'(out_valid), 0);
    step(1, 10, 1, 1, 10, 0, 0, "R9 next cycle");
    check("R9 gets returned", int'(out_new_tag), 5);
    check("R9 src via x", x, mmap[20]);
  endtask

  task automatic t_fifo_order;
    step(0, 0, 0, 0, 0, 1, 12, "R8 return A");
    step(0, 0, 0, 0, 0, 1, 40, "R8 return B");
    step(1, 0, 0, 1, 11, 1, 7, "R8 alloc A");
    check("R8 A first", int'(out_new_tag), 12);
    step(1, 11, 0, 1, 12, 0, 0, "R8 alloc B");
    check("R8 B second", int'(out_new_tag), 40);
    step(1, 12, 11, 1, 13, 0, 0, "R8 alloc C");
    check("R8 C third", int'(out_new_tag), 7);
    step(1, 13, 13, 1, 13, 0, 0, "R7 dry again");
  endtask

  initial begin
    t_reset();
    t_identity();
    t_first_alloc();
    t_idle();
    t_exhaust();
    t_commit_on_stall();
    t_fifo_order();
    t_reset();
    t_identity();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule